// File: doc/BRIEF.md
# Byte Lane Filter for Ganged Memory Emulators

One, two or four identical memory-emulator units can be ganged on a single byte-serial load stream to build an emulated memory that is 8, 16 or 32 bits wide. Every unit sees every byte that is acknowledged on the shared stream. This block sits inside each unit, between the load controller and the storage. It tracks where the current byte falls inside its group of bytes. It passes on a write only for the byte that belongs to the unit's own lane. It passes on an address-advance pulse only once per complete group.

The load controller raises `byte_evt` for one cycle per accepted byte and raises `session_end` when the load session closes. The group size comes from `width_sel` and the unit's lane comes from `lane_idx`. Both outputs are combinational in the cycle of the byte event. The position counter moves on the following clock edge.

Top module: `lane_byte_filter`

## Requirements
- R1: `width_sel` gives the group size: 2'b00 is 1 byte, 2'b01 is 2 bytes, and 2'b10 or 2'b11 is 4 bytes.
- R2: The in-group position is 0 after reset and in the cycle after `session_end`. `session_end` wins over a `byte_evt` in the same cycle, but that byte is still qualified against the old position.
- R3: During a `byte_evt` cycle, `wr_en` is 1 exactly when the current position equals the effective lane.
- R4: During a `byte_evt` cycle, `adv` is 1 exactly when the current position is the last one of the group. This gives one pulse per group.
- R5: In 8-bit width (`width_sel`=2'b00), every byte raises both `wr_en` and `adv`, whatever the value of `lane_idx`.
- R6: A `lane_idx` greater than or equal to the group size acts as lane 0.
- R7: Neither `wr_en` nor `adv` is ever 1 in a cycle without `byte_evt`.
- R8: The position moves up by one on each `byte_evt` and wraps to 0 after the last position. It holds in cycles without `byte_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_evt | input | 1 | One-cycle pulse per acknowledged byte |
| session_end | input | 1 | Load session finished; clears the position |
| width_sel | input | 2 | Bus-width code (R1) |
| lane_idx | input | 2 | Lane this unit keeps |
| wr_en | output | 1 | Qualified memory write for this byte |
| adv | output | 1 | Qualified address-counter advance |

## Verification
Random streams mix bursts of byte events, idle gaps and occasional session ends across every width and lane code. They show whether the lane match and the end-of-group pulse follow the position when bytes arrive irregularly. Directed cases cover several situations: a 16-bit unit on lane 1 that must write only on odd bytes, and a 32-bit unit on lane 3. They also cover an out-of-range lane that must behave like lane 0, and an 8-bit unit with a nonzero lane that must still accept everything. Session ends placed mid-group, including one that coincides with a byte, separate a correct restart from a counter that carries its old position into the next session.

// File: rtl/lane_byte_filter.sv
module lane_byte_filter #(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_evt,
  input  logic              session_end,
  input  logic [1:0]        width_sel,
  input  logic [LANE_W-1:0] lane_idx,
  output logic              wr_en,
  output logic              adv
);
  localparam int GW = LANE_W + 1;

  logic [GW-1:0]     gsize;
  logic [LANE_W-1:0] pos, last, eff_lane;
  logic              at_last;

  always_comb begin
    case (width_sel)
      2'b00:   gsize = GW'(1);
      2'b01:   gsize = GW'(2);
      default: gsize = GW'(4);
    endcase
  end

  assign last     = LANE_W'(gsize - GW'(1));
  assign eff_lane = ({1'b0, lane_idx} < gsize) ? lane_idx : '0;
  assign at_last  = pos >= last;
  assign wr_en    = byte_evt && (pos == eff_lane);
  assign adv      = byte_evt && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pos <= '0;
    else if (session_end)  pos <= '0;
    else if (byte_evt)     pos <= at_last ? '0 : pos + LANE_W'(1);
  end

  // R7
  wr_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> byte_evt);
  // R7
  adv_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) adv |-> byte_evt);
  // R2
  end_clears_pos_chk: assert property (@(posedge clk) disable iff (!rst_n) session_end |=> pos == '0);
  // R4
  group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) adv |=> pos == '0);
  // R5
  narrow_takes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && width_sel == 2'b00) |-> (wr_en && adv));
endmodule

// File: tb/lane_byte_filter_tb.sv
module lane_byte_filter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_evt = 1'b0, session_end = 1'b0;
  logic [1:0] width_sel = 2'b00, lane_idx = 2'b00;
  logic wr_en, adv;
  int n_cmp = 0, n_bad = 0;
  int mpos = 0;
  bit done = 0;

  lane_byte_filter dut_i (.clk(clk), .rst_n(rst_n), .byte_evt(byte_evt),
    .session_end(session_end), .width_sel(width_sel), .lane_idx(lane_idx),
    .wr_en(wr_en), .adv(adv));

  always #2 clk = ~clk;

  function automatic int gsz(logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction
  function automatic int elane(logic [1:0] w, logic [1:0] l);
    return (int'(l) < gsz(w)) ? int'(l) : 0;
  endfunction
  function automatic bit exp_wr(int p, logic [1:0] w, logic [1:0] l, bit e);
    return e && (p == elane(w, l));
  endfunction
  function automatic bit exp_adv(int p, logic [1:0] w, bit e);
    return e && (p == gsz(w) - 1);
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b (w=%0d lane=%0d pos=%0d)",
               req, act, exp, width_sel, lane_idx, mpos);
    end
  endtask

  // drive one cycle, check outputs, then advance model to match the edge
  task automatic step(bit e, bit s, string tag);
    string rq_w, rq_a;
    @(negedge clk);
    byte_evt = e; session_end = s;
    #1;
    rq_w = (tag != "") ? tag : !e ? "R7" : (width_sel == 0) ? "R5" :
           (int'(lane_idx) >= gsz(width_sel)) ? "R6" : "R3";
    rq_a = (tag != "") ? tag : !e ? "R7" : (width_sel == 0) ? "R5" : "R4";
    check(rq_w, wr_en, exp_wr(mpos, width_sel, lane_idx, e));
    check(rq_a, adv, exp_adv(mpos, width_sel, e));
    if (s) mpos = 0;
    else if (e) mpos = (mpos == gsz(width_sel) - 1) ? 0 : mpos + 1;
  endtask

  task automatic new_session(logic [1:0] w, logic [1:0] l);
    step(0, 1, "R2");
    @(negedge clk);
    width_sel = w; lane_idx = l;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    #1;
    check("R2", wr_en, 1'b0);
    check("R2", adv, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: 8-bit, nonzero lane ignored
    new_session(2'b00, 2'b11);
    repeat (3) step(1, 0, "R5");
    // R1: 16-bit lane 1 writes on odd bytes only
    new_session(2'b01, 2'b01);
    repeat (4) step(1, 0, "R1");
    // R8: idle holds position
    step(1, 0, "");
    repeat (3) step(0, 0, "R8");
    step(1, 0, "R8");
    // R1: code 2'b11 is also four bytes; lane 3
    new_session(2'b11, 2'b11);
    repeat (8) step(1, 0, "R1");
    // R6: 16-bit, lane 2 acts as lane 0
    new_session(2'b01, 2'b10);
    repeat (4) step(1, 0, "R6");
    // R2: session end mid-group, together with a byte
    new_session(2'b10, 2'b00);
    step(1, 0, "");
    step(1, 1, "R2");
    repeat (4) step(1, 0, "R2");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 39) == 0)
        new_session(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      else
        step($urandom_range(0, 2) != 0, $urandom_range(0, 99) == 0, "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule